// File: doc/BRIEF.md
# Bus Parity Halt and Trap Controller

This block sits on the processor side of the system bus. It watches the two parity status lines that a memory slave returns on every read, plus parity-halt requests from the fast memory path. A parity fault does not trap at once. The block first latches a bus parity flag when the transfer finishes. At the next pause cycle it raises a console flag, and that flag halts the processor.

When the operator presses continue, the halt drops and the block presents a trap request carrying the parity vector. A configuration input selects the older vector assignment, in which parity faults share the general CPU-error vector. Accesses to non-existent memory do not use the halt path: they request a trap straight away through the CPU-error vector, and they take priority over a parity trap.

The microcode sequencer owns the pause strobe and the acknowledge. It stacks the trap after it sees the request.

Top module: `parity_halt_trap`

## Requirements
- R1: A bus parity fault is a read cycle (`bus_read`=1 while `bus_msync`=1) with `bus_par_a`=0 and `bus_par_b`=1. The other line pairs (00, 10, 11) are clean, and a write cycle is never a fault.
- R2: The bus parity flag is set only on the first clock where `bus_msync` is seen low after being high. A pause strobe given while master sync is still asserted does not halt.
- R3: While the bus parity flag is set and the CPU is not halted, a `pause_stb` pulse makes `cpu_halt` go to 1 on the next clock. A pause strobe with no parity source leaves `cpu_halt` at 0.
- R4: Each fast-path request bit `fast_pe_req[i]` halts through the same pause path only when its own enable bit `fast_halt_en[i]` is 1. A request whose enable is 0, or an enable with no request, has no effect.
- R5: `cont_req` while `cpu_halt`=1 clears `cpu_halt` on the next clock and raises `trap_req` with the parity vector on that same clock.
- R6: The parity vector is octal 114 when `legacy_vec`=0 and octal 004 when `legacy_vec`=1.
- R7: A pulse on `nxm_err` raises `trap_req` with vector octal 004 on the next clock and never raises `cpu_halt`.
- R8: `trap_ack` while a parity trap is presented clears `trap_req` and the bus parity flag, so one fault gives exactly one halt and one trap. A later pause does not halt again, and `cont_req` while not halted produces no trap.
- R9: If a non-existent-memory fault arrives on the same clock that a parity fault is latched, the octal 004 trap is presented first. The parity flag stays pending, and a later pause halts and leads to the parity trap.
- R10: During and right after reset, `cpu_halt` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_msync | input | 1 | Master sync of the current bus transfer |
| bus_read | input | 1 | Current transfer is a read |
| bus_par_a | input | 1 | Parity status line A |
| bus_par_b | input | 1 | Parity status line B |
| fast_pe_req | input | N_FAST | Fast-path parity error requests, one per port |
| fast_halt_en | input | N_FAST | Software-set halt enables, one per fast port |
| pause_stb | input | 1 | Pause-cycle strobe from the sequencer |
| cont_req | input | 1 | Operator continue |
| legacy_vec | input | 1 | 1 selects the older parity vector (octal 004) |
| nxm_err | input | 1 | Non-existent memory fault pulse |
| trap_ack | input | 1 | Sequencer has taken the presented trap |
| cpu_halt | output | 1 | Console flag; halts the processor |
| trap_req | output | 1 | Trap request |
| trap_vec | output | VEC_W | Vector of the presented trap |

## Verification
The bench goes after the timing of the flag. If a design latched the fault while master sync was still high, it would halt on a pause given mid-transfer. The clean line pairs and a faulty-looking write are each followed by a pause, because a design with a loose decode would halt on one of them. A repeated pause after the trap is taken, and a continue while running, catch a flag that is never cleared: that design halts twice or traps without a halt. The collision of a non-existent-memory fault with a parity latch shows whether the design presents the wrong vector first or drops the parity fault altogether.

// File: rtl/ph_pkg.sv
package ph_pkg;

   localparam int unsigned PH_VEC_W = 8;
   localparam logic [PH_VEC_W-1:0] PH_PARITY_VEC = 8'o114;
   localparam logic [PH_VEC_W-1:0] PH_CPUERR_VEC = 8'o004;

   typedef enum logic [1:0] {
      TSRC_NONE = 2'd0,
      TSRC_NXM  = 2'd1,
      TSRC_PAR  = 2'd2
   } trap_src_e;

endpackage

// File: rtl/ph_bus_sense.sv
module ph_bus_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic msync,
   input  logic rd,
   input  logic par_a,
   input  logic par_b,
   input  logic clr,
   output logic flag
);

   logic msync_q;
   logic err_cap;
   logic sync_drop;

   assign sync_drop = msync_q & ~msync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msync_q <= 1'b0;
         err_cap <= 1'b0;
         flag    <= 1'b0;
      end else begin
         msync_q <= msync;
         if (msync) begin
            err_cap <= rd & ~par_a & par_b;
         end
         if (clr) begin
            flag <= 1'b0;
         end else if (sync_drop && err_cap) begin
            flag <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ph_fast_gate.sv
module ph_fast_gate #(
   parameter int unsigned N_FAST = 2
) (
   input  logic [N_FAST-1:0] req,
   input  logic [N_FAST-1:0] en,
   output logic              hit
);

   logic [N_FAST-1:0] gated;

   for (genvar i = 0; i < N_FAST; i++) begin : g_port
      assign gated[i] = req[i] & en[i];
   end

   assign hit = |gated;

endmodule

// File: rtl/ph_trap_arb.sv
module ph_trap_arb
   import ph_pkg::*;
#(
   parameter int unsigned           VEC_W   = PH_VEC_W,
   parameter logic [VEC_W-1:0]      PAR_VEC = PH_PARITY_VEC,
   parameter logic [VEC_W-1:0]      ERR_VEC = PH_CPUERR_VEC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nxm_err,
   input  logic             par_req,
   input  logic             ack,
   input  logic             legacy,
   output logic             trap_req,
   output logic [VEC_W-1:0] trap_vec,
   output logic             par_taken,
   output logic             par_pend
);

   logic      nxm_pend;
   trap_src_e src;

   always_comb begin
      if (nxm_pend)      src = TSRC_NXM;
      else if (par_pend) src = TSRC_PAR;
      else               src = TSRC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxm_pend <= 1'b0;
         par_pend <= 1'b0;
      end else begin
         if (nxm_err)                          nxm_pend <= 1'b1;
         else if (ack && (src == TSRC_NXM))    nxm_pend <= 1'b0;
         if (par_req)                          par_pend <= 1'b1;
         else if (ack && (src == TSRC_PAR))    par_pend <= 1'b0;
      end
   end

   always_comb begin
      case (src)
         TSRC_NXM: trap_vec = ERR_VEC;
         TSRC_PAR: trap_vec = legacy ? ERR_VEC : PAR_VEC;
         default:  trap_vec = '0;
      endcase
   end

   assign trap_req  = (src != TSRC_NONE);
   assign par_taken = ack && (src == TSRC_PAR);

endmodule

// File: rtl/parity_halt_trap.sv
module parity_halt_trap
   import ph_pkg::*;
#(
   parameter int unsigned       VEC_W   = PH_VEC_W,
   parameter int unsigned       N_FAST  = 2,
   parameter logic [VEC_W-1:0]  PAR_VEC = PH_PARITY_VEC,
   parameter logic [VEC_W-1:0]  ERR_VEC = PH_CPUERR_VEC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_msync,
   input  logic              bus_read,
   input  logic              bus_par_a,
   input  logic              bus_par_b,
   input  logic [N_FAST-1:0] fast_pe_req,
   input  logic [N_FAST-1:0] fast_halt_en,
   input  logic              pause_stb,
   input  logic              cont_req,
   input  logic              legacy_vec,
   input  logic              nxm_err,
   input  logic              trap_ack,
   output logic              cpu_halt,
   output logic              trap_req,
   output logic [VEC_W-1:0]  trap_vec
);

   localparam int unsigned MIN_VEC_W = $clog2(int'(PAR_VEC) + 1);

   if (VEC_W < 7) begin : g_bad_width
      $error("parity_halt_trap: VEC_W must hold octal 114");
   end
   if (N_FAST < 1) begin : g_bad_fast
      $error("parity_halt_trap: N_FAST must be at least 1");
   end
   if (PAR_VEC == ERR_VEC) begin : g_bad_vec
      $error("parity_halt_trap: parity and error vectors must differ");
   end
   if (MIN_VEC_W > VEC_W) begin : g_bad_fit
      $error("parity_halt_trap: parity vector does not fit VEC_W");
   end

   logic bus_flag;
   logic fast_hit;
   logic par_taken;
   logic par_pend;
   logic pe_set;
   logic resume;

   ph_bus_sense u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .msync (bus_msync),
      .rd    (bus_read),
      .par_a (bus_par_a),
      .par_b (bus_par_b),
      .clr   (par_taken),
      .flag  (bus_flag)
   );

   ph_fast_gate #(.N_FAST(N_FAST)) u_fast (
      .req (fast_pe_req),
      .en  (fast_halt_en),
      .hit (fast_hit)
   );

   ph_trap_arb #(.VEC_W(VEC_W), .PAR_VEC(PAR_VEC), .ERR_VEC(ERR_VEC)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxm_err   (nxm_err),
      .par_req   (resume),
      .ack       (trap_ack),
      .legacy    (legacy_vec),
      .trap_req  (trap_req),
      .trap_vec  (trap_vec),
      .par_taken (par_taken),
      .par_pend  (par_pend)
   );

   assign pe_set = pause_stb & (bus_flag | fast_hit) & ~cpu_halt & ~par_pend;
   assign resume = cpu_halt & cont_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_halt <= 1'b0;
      end else if (pe_set) begin
         cpu_halt <= 1'b1;
      end else if (resume) begin
         cpu_halt <= 1'b0;
      end
   end

endmodule

// File: rtl/ph_chk.sv
module ph_chk #(
   parameter int unsigned       VEC_W   = 8,
   parameter logic [VEC_W-1:0]  PAR_VEC = 8'o114,
   parameter logic [VEC_W-1:0]  ERR_VEC = 8'o004
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pause_stb,
   input logic             cont_req,
   input logic             nxm_err,
   input logic             cpu_halt,
   input logic             trap_req,
   input logic [VEC_W-1:0] trap_vec
);

   // R3: the halt only ever starts after a pause strobe
   p_halt_after_pause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_halt) |-> $past(pause_stb));

   // R5: continue while halted resumes and presents a trap
   p_cont_resumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt && cont_req |=> !cpu_halt && trap_req);

   // R6: only the two defined vectors are ever presented
   p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_vec == PAR_VEC) || (trap_vec == ERR_VEC));

   // R7: a non-existent memory fault presents the error vector next
   p_nxm_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nxm_err |=> trap_req && (trap_vec == ERR_VEC));

   // R7: a non-existent memory fault alone does not halt
   p_nxm_no_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nxm_err && !cpu_halt && !pause_stb |=> !cpu_halt);

endmodule

bind parity_halt_trap ph_chk #(
   .VEC_W   (VEC_W),
   .PAR_VEC (PAR_VEC),
   .ERR_VEC (ERR_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pause_stb (pause_stb),
   .cont_req  (cont_req),
   .nxm_err   (nxm_err),
   .cpu_halt  (cpu_halt),
   .trap_req  (trap_req),
   .trap_vec  (trap_vec)
);

// File: tb/parity_halt_trap_tb_top.sv
`timescale 1ns/1ps
module parity_halt_trap_tb_top;

   localparam int VEC_W  = 8;
   localparam int N_FAST = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_msync = 1'b0, bus_read = 1'b0, bus_par_a = 1'b0, bus_par_b = 1'b0;
   logic [N_FAST-1:0] fast_pe_req = '0, fast_halt_en = '0;
   logic              pause_stb = 1'b0, cont_req = 1'b0, legacy_vec = 1'b0;
   logic              nxm_err = 1'b0, trap_ack = 1'b0;
   logic              cpu_halt, trap_req;
   logic [VEC_W-1:0]  trap_vec;

   int    checks = 0;
   int    errors = 0;
   bit    run = 1'b0;
   bit    done = 1'b0;
   string tag = "R10";

   always #2 clk = ~clk;

   parity_halt_trap #(.VEC_W(VEC_W), .N_FAST(N_FAST)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_msync    (bus_msync),
      .bus_read     (bus_read),
      .bus_par_a    (bus_par_a),
      .bus_par_b    (bus_par_b),
      .fast_pe_req  (fast_pe_req),
      .fast_halt_en (fast_halt_en),
      .pause_stb    (pause_stb),
      .cont_req     (cont_req),
      .legacy_vec   (legacy_vec),
      .nxm_err      (nxm_err),
      .trap_ack     (trap_ack),
      .cpu_halt     (cpu_halt),
      .trap_req     (trap_req),
      .trap_vec     (trap_vec)
   );

   // behavioural reference
   bit m_flag, m_halt, m_nxm, m_par, m_msq, m_cap;

   always @(posedge clk) begin
      bit o_flag, o_halt, o_nxm, o_par, o_msq, o_cap, fast, par_ack, nxm_ack;
      if (!rst_n) begin
         m_flag = 0; m_halt = 0; m_nxm = 0; m_par = 0; m_msq = 0; m_cap = 0;
      end else begin
         o_flag = m_flag; o_halt = m_halt; o_nxm = m_nxm;
         o_par = m_par; o_msq = m_msq; o_cap = m_cap;
         fast    = (fast_pe_req & fast_halt_en) != '0;
         par_ack = trap_ack && !o_nxm && o_par;
         nxm_ack = trap_ack && o_nxm;
         if (bus_msync) m_cap = bus_read && !bus_par_a && bus_par_b;
         m_msq = bus_msync;
         if (par_ack) m_flag = 0;
         else if (o_msq && !bus_msync && o_cap) m_flag = 1;
         if (pause_stb && (o_flag || fast) && !o_halt && !o_par) m_halt = 1;
         else if (o_halt && cont_req) m_halt = 0;
         if (o_halt && cont_req) m_par = 1;
         else if (par_ack) m_par = 0;
         if (nxm_err) m_nxm = 1;
         else if (nxm_ack) m_nxm = 0;
      end
   end

   always @(negedge clk) begin
      logic [VEC_W-1:0] e_vec;
      bit e_req;
      if (rst_n && run && !done) begin
         e_req = m_nxm || m_par;
         e_vec = m_nxm ? 8'o004 : (legacy_vec ? 8'o004 : 8'o114);
         checks++;
         if (cpu_halt !== m_halt || trap_req !== e_req || (e_req && trap_vec !== e_vec)) begin
            errors++;
            $display("FAIL %s model: halt=%0b req=%0b vec=%o expected halt=%0b req=%0b vec=%o",
                     tag, cpu_halt, trap_req, trap_vec, m_halt, e_req, e_vec);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %o expected %o", req, act, exp);
      end
   endtask

   task automatic bus_cycle(input bit rd, input bit pa, input bit pb);
      bus_msync = 1; bus_read = rd; bus_par_a = pa; bus_par_b = pb;
      cyc(2);
      bus_msync = 0; bus_read = 0; bus_par_a = 0; bus_par_b = 0;
      cyc(1);
   endtask

   task automatic pause_pulse();
      pause_stb = 1; cyc(1); pause_stb = 0;
   endtask

   task automatic cont_pulse();
      cont_req = 1; cyc(1); cont_req = 0;
   endtask

   task automatic ack_pulse();
      trap_ack = 1; cyc(1); trap_ack = 0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      chk("R10", {7'd0, cpu_halt}, 8'd0);
      rst_n = 1; run = 1;
      cyc(1);
      chk("R10", {7'd0, trap_req}, 8'd0);

      // R1: clean patterns and a write never halt
      tag = "R1";
      bus_cycle(1, 0, 0); pause_pulse(); chk("R1 read 00", {7'd0, cpu_halt}, 8'd0);
      bus_cycle(1, 1, 0); pause_pulse(); chk("R1 read 10", {7'd0, cpu_halt}, 8'd0);
      bus_cycle(1, 1, 1); pause_pulse(); chk("R1 read 11", {7'd0, cpu_halt}, 8'd0);
      bus_cycle(0, 0, 1); pause_pulse(); chk("R1 write 01", {7'd0, cpu_halt}, 8'd0);
      bus_cycle(1, 0, 1); pause_pulse(); chk("R1 read 01", {7'd0, cpu_halt}, 8'd1);
      cont_pulse(); ack_pulse();

      // R2: pause during master sync does not halt
      tag = "R2";
      bus_msync = 1; bus_read = 1; bus_par_a = 0; bus_par_b = 1;
      cyc(2);
      pause_pulse();
      chk("R2", {7'd0, cpu_halt}, 8'd0);
      bus_msync = 0; bus_read = 0; bus_par_b = 0;
      cyc(1);
      tag = "R3";
      pause_pulse();
      chk("R3", {7'd0, cpu_halt}, 8'd1);
      tag = "R5";
      cont_pulse();
      chk("R5 halt", {7'd0, cpu_halt}, 8'd0);
      chk("R5 req", {7'd0, trap_req}, 8'd1);
      chk("R6 vec", trap_vec, 8'o114);
      tag = "R8";
      ack_pulse();
      chk("R8 req", {7'd0, trap_req}, 8'd0);
      pause_pulse();
      chk("R8 no rehalt", {7'd0, cpu_halt}, 8'd0);
      cont_pulse();
      chk("R8 stray cont", {7'd0, trap_req}, 8'd0);

      // R6: legacy vector
      tag = "R6";
      legacy_vec = 1;
      bus_cycle(1, 0, 1); pause_pulse(); cont_pulse();
      chk("R6 legacy", trap_vec, 8'o004);
      ack_pulse();
      legacy_vec = 0;

      // R4: fast path gating
      tag = "R4";
      fast_pe_req = 2'b01; fast_halt_en = 2'b00; pause_pulse();
      chk("R4 no enable", {7'd0, cpu_halt}, 8'd0);
      fast_halt_en = 2'b10; pause_pulse();
      chk("R4 other port", {7'd0, cpu_halt}, 8'd0);
      fast_pe_req = 2'b10; pause_pulse();
      chk("R4 enabled", {7'd0, cpu_halt}, 8'd1);
      fast_pe_req = 2'b00; fast_halt_en = 2'b00;
      cont_pulse();
      chk("R4 vec", trap_vec, 8'o114);
      ack_pulse();

      // R7: non-existent memory
      tag = "R7";
      nxm_err = 1; cyc(1); nxm_err = 0;
      chk("R7 req", {7'd0, trap_req}, 8'd1);
      chk("R7 vec", trap_vec, 8'o004);
      chk("R7 halt", {7'd0, cpu_halt}, 8'd0);
      ack_pulse();
      chk("R7 cleared", {7'd0, trap_req}, 8'd0);

      // R9: collision
      tag = "R9";
      bus_msync = 1; bus_read = 1; bus_par_a = 0; bus_par_b = 1;
      cyc(2);
      bus_msync = 0; bus_read = 0; bus_par_b = 0; nxm_err = 1;
      cyc(1);
      nxm_err = 0;
      chk("R9 first vec", trap_vec, 8'o004);
      ack_pulse();
      chk("R9 req after ack", {7'd0, trap_req}, 8'd0);
      pause_pulse();
      chk("R9 pending halt", {7'd0, cpu_halt}, 8'd1);
      cont_pulse();
      chk("R9 parity vec", trap_vec, 8'o114);
      ack_pulse();
      chk("R9 done", {7'd0, trap_req}, 8'd0);

      cyc(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule